// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is a single private timer for one processor. Software programs it through four 32-bit words: a reload value, the live count, a control word and a sticky expiry flag. While enabled and holding a non-zero count, the timer decrements once every (P+1) clock cycles, where P is an 8-bit prescale field in the control word.

When the count steps from one to zero the timer has expired. The expiry flag is set and stays set until software clears it by writing a one. In periodic mode the count is refilled from the reload word and counting continues. In one-shot mode the count rests at zero.

A one-clock interrupt pulse marks each cycle in which the flag goes from clear to set. Writing the reload word also overwrites the live count. Writing either the reload word or the count, or turning the enable on, restarts the prescale phase from zero.

Top module: `ptimer`

## Requirements
- R1: A synchronous active-high reset clears the reload word, count, control, flag and the prescale phase to zero, and holds `irq` low.
- R2: The word is selected by `addr[3:2]`: byte offset 0x0 is the reload word, 0x4 the count, 0x8 control, and 0xC the flag in bit 0. In control, bit 0 is enable, bit 1 is periodic mode and bits 15:8 are the prescale value P. All other control bits are dropped on write and read back as zero. `rdData` follows `addr` in the same cycle.
- R3: While enabled with a non-zero count, the count drops by one every P+1 cycles. After a restart the first decrement comes P+1 cycles later. A restart is a write to the reload word or the count, or enable going from 0 to 1.
- R4: A decrement from 1 to 0 sets the flag.
- R5: In periodic mode that expiring step loads the count from the reload word instead of zero.
- R6: In one-shot mode the count stays at zero after expiry, and no further expiry follows.
- R7: A write to offset 0x0 stores the value in both the reload word and the live count.
- R8: A write to offset 0x4 replaces the count with the written value.
- R9: A control write that turns enable from 0 to 1 with periodic mode set in the written value, while the count is zero, first loads the count from the reload word.
- R10: Reading offset 0x4 returns zero while the timer is disabled or the count is zero. While disabled, the count holds unless written.
- R11: A write to 0xC with bit 0 set clears the flag. When an expiry falls in the same cycle, the flag stays set.
- R12: `irq` is high for exactly one cycle, the one in which the flag first reads 1 after being 0. A fresh expiry while the flag is already set gives no pulse.
- R13: A write to the reload word or the count in the same cycle as a due decrement takes precedence. That decrement and its expiry are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one base tick |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the word at `addr` |
| addr | input | 4 | Byte offset of the selected word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the word at `addr` |
| irq | output | 1 | One-cycle pulse on a new expiry flag |

## Verification
Two functions can fall in the same cycle. The first is an expiry, a count reaching zero. The second is a software write: either a write-one-to-clear of the flag, or a write to the reload word or the count. Both cases are set up directly, with prescale 0 and a count of 1, by issuing the write on the cycle the expiry is due. The expected result is that the flag survives the clear with no new pulse, and that a count write wins with no expiry recorded. The constrained-random phase uses tiny reload values and prescales so that these collisions occur often. Every cycle is then judged against a cycle-level model of the requirements.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_FLAG   = 2'd3
  } regSel_t;

  typedef struct packed {
    logic wrReload;
    logic wrCount;
    logic wrCtrl;
    logic wrFlag;
    logic enRise;
    logic decEvent;
  } tmrStrobe_t;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_PER_BIT  = 1;
  localparam int unsigned CTRL_PRE_LSB  = 8;

endpackage

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
  import ptimer_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [3:0]       addr,
  input  logic             wrEnBit,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic             countZero,
  output tmrStrobe_t       strb
);

  regSel_t          sel;
  logic [PRE_W-1:0] preCnt;
  logic             restart;
  logic             running;

  always_comb begin
    sel           = regSel_t'(addr[3:2]);
    strb.wrReload = wrEn && (sel == SEL_RELOAD);
    strb.wrCount  = wrEn && (sel == SEL_COUNT);
    strb.wrCtrl   = wrEn && (sel == SEL_CTRL);
    strb.wrFlag   = wrEn && (sel == SEL_FLAG);
    strb.enRise   = strb.wrCtrl && !enable && wrEnBit;
    restart       = strb.wrReload || strb.wrCount || strb.enRise;
    running       = enable && !countZero;
    // a phase beyond a newly lowered prescale still fires at once
    strb.decEvent = !restart && running && (preCnt >= prescale);
  end

  always_ff @(posedge clk) begin
    if (rst)                preCnt <= '0;
    else if (restart)       preCnt <= '0;
    else if (strb.decEvent) preCnt <= '0;
    else if (running)       preCnt <= preCnt + 1'b1;
  end

  // R3: with a non-zero prescale two decrements are never adjacent
  assert_prescale_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.decEvent && prescale != '0 && !strb.wrCtrl) |=> !strb.decEvent);

  // R13: a restart in the same cycle always suppresses the decrement
  assert_restart_wins_R13: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCount || strb.wrReload) |-> !strb.decEvent);

  // R3: a restart leaves the phase at zero
  assert_phase_cleared_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCount || strb.wrReload || strb.enRise) |=> preCnt == '0);

endmodule

// File: rtl/ptimer_datapath.sv
module ptimer_datapath
  import ptimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobe_t        strb,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              enable,
  output logic [PRE_W-1:0]  prescale,
  output logic              countZero
);

  localparam int unsigned PRE_MSB = CTRL_PRE_LSB + PRE_W - 1;

  logic [DATA_W-1:0] reloadReg;
  logic [DATA_W-1:0] countReg;
  logic              periodic;
  logic              flag;
  logic              expire;
  logic              flagNext;
  logic [DATA_W-1:0] countNext;
  logic [DATA_W-1:0] ctrlView;

  always_comb begin
    countZero = (countReg == '0);
    expire    = strb.decEvent && (countReg == DATA_W'(1));

    flagNext = flag;
    if (strb.wrFlag && wrData[0]) flagNext = 1'b0;
    if (expire)                   flagNext = 1'b1;

    countNext = countReg;
    if (strb.wrReload || strb.wrCount)
      countNext = wrData;
    else if (strb.enRise && countZero && wrData[CTRL_PER_BIT])
      countNext = reloadReg;
    else if (expire)
      countNext = periodic ? reloadReg : '0;
    else if (strb.decEvent)
      countNext = countReg - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reloadReg <= '0;
      countReg  <= '0;
      enable    <= 1'b0;
      periodic  <= 1'b0;
      prescale  <= '0;
      flag      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (strb.wrReload) reloadReg <= wrData;
      if (strb.wrCtrl) begin
        enable   <= wrData[CTRL_EN_BIT];
        periodic <= wrData[CTRL_PER_BIT];
        prescale <= wrData[PRE_MSB:CTRL_PRE_LSB];
      end
      countReg <= countNext;
      flag     <= flagNext;
      irq      <= flagNext && !flag;
    end
  end

  always_comb begin
    ctrlView                         = '0;
    ctrlView[CTRL_EN_BIT]            = enable;
    ctrlView[CTRL_PER_BIT]           = periodic;
    ctrlView[PRE_MSB:CTRL_PRE_LSB]   = prescale;
    unique case (regSel_t'(addr[3:2]))
      SEL_RELOAD: rdData = reloadReg;
      SEL_COUNT:  rdData = (enable && !countZero) ? countReg : '0;
      SEL_CTRL:   rdData = ctrlView;
      SEL_FLAG:   rdData = {{(DATA_W-1){1'b0}}, flag};
      default:    rdData = '0;
    endcase
  end

  // R6: one-shot expiry parks the count at zero
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic) |=> (countReg == '0) && flag);

  // R5: periodic expiry refills from the reload word
  assert_periodic_refill_R5: assert property (@(posedge clk) disable iff (rst)
    (expire && periodic) |=> countReg == $past(reloadReg));

  // R12: a pulse only accompanies a fresh flag
  assert_irq_on_rise_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && !$past(flag)));

  // R11: the flag stays set unless cleared by a one in bit 0
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (flag && !(strb.wrFlag && wrData[0])) |=> flag);

  // R10: a disabled timer holds its count unless written
  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (!enable && !strb.wrCtrl && !strb.wrCount && !strb.wrReload) |=> $stable(countReg));

  // R8: a count write lands as written
  assert_count_write_R8: assert property (@(posedge clk) disable iff (rst)
    strb.wrCount |=> countReg == $past(wrData));

endmodule

// File: rtl/ptimer.sv
module ptimer
  import ptimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  tmrStrobe_t       strb;
  logic             enable;
  logic [PRE_W-1:0] prescale;
  logic             countZero;

  ptimer_ctrl #(.PRE_W(PRE_W)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrEnBit   (wrData[CTRL_EN_BIT]),
    .enable    (enable),
    .prescale  (prescale),
    .countZero (countZero),
    .strb      (strb)
  );

  ptimer_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) uData (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .addr      (addr),
    .wrData    (wrData),
    .rdData    (rdData),
    .irq       (irq),
    .enable    (enable),
    .prescale  (prescale),
    .countZero (countZero)
  );

endmodule

// File: tb/ptimer_test.sv
`timescale 1ns/1ps
module ptimer_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [3:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // model state
  logic [31:0] mReload, mCount;
  logic        mEn, mPer, mFlag, mIrq;
  logic [7:0]  mPre, mPhase;

  always #4 clk = ~clk;

  ptimer uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a[3:2])
      2'd0: return mReload;
      2'd1: return (mEn && mCount != 0) ? mCount : 32'd0;
      2'd2: return {16'd0, mPre, 6'd0, mPer, mEn};
      default: return {31'd0, mFlag};
    endcase
  endfunction

  function automatic void modelReset();
    mReload = 0; mCount = 0; mEn = 0; mPer = 0; mFlag = 0; mIrq = 0;
    mPre = 0; mPhase = 0;
  endfunction

  function automatic void modelStep(input logic we, input logic [3:0] a, input logic [31:0] d);
    logic rise, restart, run, dec, exp, nFlag;
    logic [31:0] nCount;
    rise    = we && a[3:2] == 2'd2 && !mEn && d[0];
    restart = (we && (a[3:2] == 2'd0 || a[3:2] == 2'd1)) || rise;
    run     = mEn && mCount != 0;
    dec     = !restart && run && (mPhase >= mPre);
    exp     = dec && mCount == 1;
    nFlag = mFlag;
    if (we && a[3:2] == 2'd3 && d[0]) nFlag = 0;
    if (exp) nFlag = 1;
    nCount = mCount;
    if (we && (a[3:2] == 2'd0 || a[3:2] == 2'd1)) nCount = d;
    else if (rise && mCount == 0 && d[1]) nCount = mReload;
    else if (exp) nCount = mPer ? mReload : 32'd0;
    else if (dec) nCount = mCount - 1;
    if (restart || dec) mPhase = 0;
    else if (run) mPhase = mPhase + 1;
    if (we && a[3:2] == 2'd0) mReload = d;
    if (we && a[3:2] == 2'd2) begin
      mEn = d[0]; mPer = d[1]; mPre = d[15:8];
    end
    mIrq = nFlag && !mFlag;
    mFlag = nFlag;
    mCount = nCount;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tagFor(input logic [1:0] s);
    case (s)
      2'd0: return "R7";
      2'd1: return "R3";
      2'd2: return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic compareAll();
    for (int i = 0; i < 4; i++) begin
      addr = 4'(i * 4);
      #0.5;
      check(tagFor(2'(i)), rdData, modelRead(addr));
    end
    check("R12", {31'd0, irq}, {31'd0, mIrq});
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d);
    wrEn = we; addr = a; wrData = d;
    @(posedge clk);
    modelStep(we, a, d);
    @(negedge clk);
    wrEn = 0;
    compareAll();
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #0.5; v = rdData;
  endtask

  task automatic finish();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst = 1; wrEn = 0; addr = 0; wrData = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: everything reads zero after reset
    for (int i = 0; i < 4; i++) begin
      rd(4'(i * 4), v); check("R1", v, 32'd0);
    end
    check("R1", {31'd0, irq}, 32'd0);

    // one-shot, prescale 2, reload 3; junk control bits dropped (R2)
    step(1, 4'h8, 32'hFFFF_02F0);
    rd(4'h8, v); check("R2", v, 32'h0000_0200);
    step(1, 4'h0, 32'd3);
    rd(4'h4, v); check("R10", v, 32'd0);   // disabled reads zero
    rd(4'h0, v); check("R7", v, 32'd3);
    step(1, 4'h8, 32'h0000_0201);           // enable: restart
    step(0, 0, 0); step(0, 0, 0);
    rd(4'h4, v); check("R3", v, 32'd3);
    step(0, 0, 0);
    rd(4'h4, v); check("R3", v, 32'd2);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    check("R12", {31'd0, irq}, 32'd0);
    step(0, 0, 0);
    check("R12", {31'd0, irq}, 32'd1);
    rd(4'hC, v); check("R4", v, 32'd1);
    rd(4'h4, v); check("R6", v, 32'd0);
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    rd(4'h4, v); check("R6", v, 32'd0);
    check("R12", {31'd0, irq}, 32'd0);
    step(1, 4'hC, 32'd1);
    rd(4'hC, v); check("R11", v, 32'd0);

    // R9: enable periodic from zero count seeds from reload
    step(1, 4'h8, 32'd0);
    step(1, 4'h8, 32'h0000_0003);
    rd(4'h4, v); check("R9", v, 32'd3);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    rd(4'h4, v); check("R5", v, 32'd3);
    rd(4'hC, v); check("R4", v, 32'd1);
    step(1, 4'hC, 32'd1);
    step(1, 4'h4, 32'd5);
    rd(4'h4, v); check("R8", v, 32'd5);
    // R13: count write on the cycle expiry is due
    step(1, 4'h4, 32'd1);
    step(1, 4'h4, 32'd4);
    rd(4'h4, v); check("R13", v, 32'd4);
    rd(4'hC, v); check("R13", v, 32'd0);
    // R11: clear in the expiry cycle loses, no second pulse
    step(1, 4'h4, 32'd1);
    step(0, 0, 0);                          // expires, flag set
    step(1, 4'h4, 32'd1);
    step(1, 4'hC, 32'd1);                   // expiry again, same cycle
    rd(4'hC, v); check("R11", v, 32'd1);
    check("R12", {31'd0, irq}, 32'd0);

    // constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [31:0] d;
      r = $urandom % 16;
      case (r)
        10: step(1, 4'h0, ($urandom % 8 == 0) ? 32'd0 : 32'($urandom % 6 + 1));
        11: step(1, 4'h4, 32'($urandom % 7));
        12: begin
          d = $urandom & 32'hFFFF_00FC;
          d[15:8] = 8'($urandom % 4);
          d[1:0] = 2'($urandom);
          step(1, 4'h8, d);
        end
        13: step(1, 4'hC, $urandom);
        default: step(0, 4'($urandom), $urandom);
      endcase
    end
    rst = 1;
    @(posedge clk); modelReset();
    @(negedge clk); rst = 0;
    compareAll();
    finish();
  end

endmodule